// File: doc/BRIEF.md
# Neighbor Memory Access Router

This block sits between one compute tile in a two-dimensional tile array and the data memories that tile can reach. A tile can reach its own memory, the memory of the tile above it, the memory of the tile below it, and one memory beside it. The router presents these four memories as one flat 128 KB window. The top two bits of each load or store address pick the memory. The remaining bits pick a bank and a 32-bit word inside it. The router raises the request on exactly one of five physical ports: own, north, south, east and west.

The side memory sits to the west on even rows and to the east on odd rows, because the tile layout is mirrored from one row to the next. Tiles on the border of the array are missing one or two of the memories. A request aimed at a missing memory is dropped. It raises an error pulse, and if it was a read it returns zero. Read data comes back in the cycle after the request. It is selected from the port that was chosen when the request was issued. The row and column of the tile are static inputs.

Top module: `nbr_mem_router`

## Requirements
- R1: Address bits [16:15] choose the logical target: 0 south, 1 side neighbour, 2 own memory, 3 north.
- R2: Physical port bits of port_req/port_we are 0 own, 1 north, 2 south, 3 east, 4 west. The side neighbour maps to west (bit 4) when tile_row is even and to east (bit 3) when it is odd.
- R3: In the same cycle as the request, port_bank carries address bits [14:12], port_word carries bits [11:2], and port_wdata carries req_wdata.
- R4: At most one bit of port_req is high in any cycle, and none is high while req_valid is low.
- R5: A port_we bit is high only together with the same port_req bit, and only on a write (req_we high). A write stores data that a later read of the same address returns.
- R6: A request to a missing memory raises no port bit and sets acc_err high for exactly the one cycle after the request. Missing memories are: south on row 0, north on row ROWS-1, west on column 0, and east on column COLS-1.
- R7: In the cycle after a read request, rd_valid is high and rd_data equals the port_rdata slice of the chosen port. Outside such cycles, rd_data is zero.
- R8: A read of a missing memory gives rd_valid high with rd_data zero.
- R9: A write request never produces rd_valid.
- R10: While rst is high, rd_valid and acc_err are low on the following cycle, even when a request is presented.
- R11: Back-to-back reads to different memories each return the data of their own port, because the port choice is held from issue time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tile_row | input | ROW_W (2) | Row of this tile, 0 is the bottom row |
| tile_col | input | COL_W (3) | Column of this tile |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W (17) | Byte address in the 128 KB window |
| req_wdata | input | DATA_W (32) | Store data |
| port_req | output | NPORT (5) | One-hot request per physical port |
| port_we | output | NPORT (5) | Write strobe per physical port |
| port_bank | output | BANK_W (3) | Bank index inside the target memory |
| port_word | output | WORD_W (10) | Word index inside the bank |
| port_wdata | output | DATA_W (32) | Store data to the target memory |
| port_rdata | input | NPORT*DATA_W (160) | Read data returned by each port, one cycle after its request |
| rd_valid | output | 1 | Read result present |
| rd_data | output | DATA_W (32) | Read result |
| acc_err | output | 1 | Pulse for a request to a missing memory |

## Verification
Some properties are checked on every cycle: the one-hot port request, write strobes confined to the active port and to stores, the pairing of acc_err with a dropped request, rd_valid following reads but never writes, zero data on error reads, and the reset behaviour. Other behaviour can only be shown by the bench's scenarios. These are the address-to-direction map, the even/odd row mirroring of the side neighbour, the edge cases at each border, the bank and word fields, and data integrity through a store followed by a load. The bench also covers back-to-back reads that must each return from their own port.

// File: rtl/nbr_router_pkg.sv
package nbr_router_pkg;

  typedef enum logic [1:0] {
    LDIR_SOUTH = 2'd0,
    LDIR_SIDE  = 2'd1,
    LDIR_OWN   = 2'd2,
    LDIR_NORTH = 2'd3
  } ldir_e;

  localparam int NPORT  = 5;
  localparam int PORT_W = 3;

  localparam logic [PORT_W-1:0] PORT_OWN   = 3'd0;
  localparam logic [PORT_W-1:0] PORT_NORTH = 3'd1;
  localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd2;
  localparam logic [PORT_W-1:0] PORT_EAST  = 3'd3;
  localparam logic [PORT_W-1:0] PORT_WEST  = 3'd4;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic              present;
  } route_t;

endpackage

// File: rtl/nbr_addr_decode.sv
module nbr_addr_decode
  import nbr_router_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BANKS  = 8,
  localparam int MOD_AW = ADDR_W - 2,
  localparam int BANK_W = $clog2(BANKS),
  localparam int WORD_W = MOD_AW - BANK_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output ldir_e             ldir,
  output logic [BANK_W-1:0] bank,
  output logic [WORD_W-1:0] word
);

  logic unused_byte_lane;

  assign ldir = ldir_e'(addr[ADDR_W-1 -: 2]);
  assign bank = addr[MOD_AW-1 -: BANK_W];
  assign word = addr[WORD_W+1:2];
  assign unused_byte_lane = ^addr[1:0];

endmodule

// File: rtl/nbr_dir_map.sv
module nbr_dir_map
  import nbr_router_pkg::*;
#(
  parameter int ROWS          = 4,
  parameter int COLS          = 6,
  parameter bit EVEN_ROW_WEST = 1'b1,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  ldir_e            ldir,
  output route_t           route
);

  logic side_west;
  logic has_south, has_north, has_west, has_east;

  generate
    if (EVEN_ROW_WEST) begin : g_even_west
      assign side_west = ~row[0];
    end else begin : g_even_east
      assign side_west = row[0];
    end
  endgenerate

  assign has_south = (row != '0);
  assign has_north = (row != ROW_W'(ROWS - 1));
  assign has_west  = (col != '0);
  assign has_east  = (col != COL_W'(COLS - 1));

  always_comb begin
    route = '{port: PORT_OWN, present: 1'b1};
    unique case (ldir)
      LDIR_SOUTH: route = '{port: PORT_SOUTH, present: has_south};
      LDIR_NORTH: route = '{port: PORT_NORTH, present: has_north};
      LDIR_OWN:   route = '{port: PORT_OWN,   present: 1'b1};
      LDIR_SIDE: begin
        if (side_west) route = '{port: PORT_WEST, present: has_west};
        else           route = '{port: PORT_EAST, present: has_east};
      end
      default:    route = '{port: PORT_OWN,   present: 1'b1};
    endcase
  end

endmodule

// File: rtl/nbr_req_fanout.sv
module nbr_req_fanout
  import nbr_router_pkg::*;
#(
  parameter int NP = NPORT
) (
  input  logic          valid,
  input  logic          we,
  input  route_t        route,
  output logic [NP-1:0] req,
  output logic [NP-1:0] wstb
);

  logic fire;
  assign fire = valid & route.present;

  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      assign req[p]  = fire & (route.port == PORT_W'(p));
      assign wstb[p] = req[p] & we;
    end
  endgenerate

endmodule

// File: rtl/nbr_rsp_return.sv
module nbr_rsp_return
  import nbr_router_pkg::*;
#(
  parameter int NP     = NPORT,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic                 we,
  input  route_t               route,
  input  logic [NP*DATA_W-1:0] rdata_all,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 err
);

  logic [PORT_W-1:0] sel_q;
  logic              zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      err      <= 1'b0;
      sel_q    <= '0;
      zero_q   <= 1'b1;
    end else begin
      rd_valid <= valid & ~we;
      err      <= valid & ~route.present;
      if (valid) begin
        sel_q  <= route.port;
        zero_q <= ~route.present;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_valid && !zero_q) begin
      for (int p = 0; p < NP; p++) begin
        if (sel_q == PORT_W'(p)) rd_data = rdata_all[p*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/nbr_mem_router.sv
module nbr_mem_router
  import nbr_router_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 6,
  parameter int ADDR_W = 17,
  parameter int BANKS  = 8,
  parameter int DATA_W = 32,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int BANK_W = $clog2(BANKS),
  localparam int WORD_W = ADDR_W - 2 - BANK_W - 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ROW_W-1:0]        tile_row,
  input  logic [COL_W-1:0]        tile_col,
  input  logic                    req_valid,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic [NPORT-1:0]        port_req,
  output logic [NPORT-1:0]        port_we,
  output logic [BANK_W-1:0]       port_bank,
  output logic [WORD_W-1:0]       port_word,
  output logic [DATA_W-1:0]       port_wdata,
  input  logic [NPORT*DATA_W-1:0] port_rdata,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic                    acc_err
);

  ldir_e  ldir;
  route_t route;

  nbr_addr_decode #(.ADDR_W(ADDR_W), .BANKS(BANKS)) u_dec (
    .addr (req_addr),
    .ldir (ldir),
    .bank (port_bank),
    .word (port_word)
  );

  nbr_dir_map #(.ROWS(ROWS), .COLS(COLS), .EVEN_ROW_WEST(1'b1)) u_map (
    .row   (tile_row),
    .col   (tile_col),
    .ldir  (ldir),
    .route (route)
  );

  nbr_req_fanout #(.NP(NPORT)) u_fan (
    .valid (req_valid),
    .we    (req_we),
    .route (route),
    .req   (port_req),
    .wstb  (port_we)
  );

  nbr_rsp_return #(.NP(NPORT), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .valid     (req_valid),
    .we        (req_we),
    .route     (route),
    .rdata_all (port_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .err       (acc_err)
  );

  assign port_wdata = req_wdata;

endmodule

// File: rtl/nbr_mem_router_chk.sv
module nbr_mem_router_chk #(
  parameter int NP     = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_we,
  input logic [NP-1:0]     port_req,
  input logic [NP-1:0]     port_we,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              acc_err
);

  assert_one_port_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(port_req) && (req_valid || port_req == '0));

  assert_we_on_port_R5: assert property (@(posedge clk) disable iff (rst)
    ((port_we & ~port_req) == '0) && (req_we || port_we == '0));

  assert_err_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && port_req == '0) |=> acc_err);

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_err && !$past(rst)) |-> ($past(req_valid) && $past(port_req) == '0));

  assert_read_returns_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_we) |=> rd_valid);

  assert_idle_data_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0);

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && acc_err) |-> rd_data == '0);

  assert_write_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_we) |=> !rd_valid);

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rd_valid && !acc_err));

endmodule

bind nbr_mem_router nbr_mem_router_chk #(.NP(nbr_router_pkg::NPORT), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_we    (req_we),
  .port_req  (port_req),
  .port_we   (port_we),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .acc_err   (acc_err)
);

// File: tb/nbr_mem_router_bench.sv
`timescale 1ns/1ps
module nbr_mem_router_bench;

  localparam int NP = 5;
  localparam int DW = 32;
  localparam int NONE = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    tile_row = '0;
  logic [2:0]    tile_col = '0;
  logic          req_valid = 1'b0;
  logic          req_we = 1'b0;
  logic [16:0]   req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [NP-1:0] port_req, port_we;
  logic [2:0]    port_bank;
  logic [9:0]    port_word;
  logic [31:0]   port_wdata;
  logic [NP*DW-1:0] port_rdata;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic          acc_err;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  nbr_mem_router u_nbr_mem_router (
    .clk(clk), .rst(rst), .tile_row(tile_row), .tile_col(tile_col),
    .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .port_req(port_req), .port_we(port_we), .port_bank(port_bank), .port_word(port_word),
    .port_wdata(port_wdata), .port_rdata(port_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err)
  );

  // memory model behind each physical port: 8 banks x 1024 words
  logic [31:0] mem [NP][8192];
  logic [31:0] rdq [NP];

  initial begin
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < 8192; i++)
        mem[p][i] = (32'(p) << 28) | 32'h0550_0000 | 32'(i);
  end

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (port_req[p]) begin
        if (port_we[p]) mem[p][{port_bank, port_word}] <= port_wdata;
        else            rdq[p] <= mem[p][{port_bank, port_word}];
      end
    end
  end

  always_comb
    for (int p = 0; p < NP; p++) port_rdata[p*DW +: DW] = rdq[p];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {row[2], col[3], we[1], addr[17], expected port[3]}
  localparam int NV = 14;
  localparam logic [25:0] VEC [NV] = '{
    {2'd1, 3'd2, 1'b0, 17'h11234, 3'd0},  // own
    {2'd1, 3'd2, 1'b0, 17'h18F00, 3'd1},  // north
    {2'd1, 3'd2, 1'b0, 17'h07FFC, 3'd2},  // south, last word of last bank
    {2'd1, 3'd2, 1'b0, 17'h08010, 3'd3},  // odd row side -> east
    {2'd2, 3'd2, 1'b0, 17'h0C444, 3'd4},  // even row side -> west
    {2'd0, 3'd3, 1'b0, 17'h00100, 3'd7},  // bottom row south missing
    {2'd3, 3'd3, 1'b0, 17'h18100, 3'd7},  // top row north missing
    {2'd2, 3'd0, 1'b0, 17'h08020, 3'd7},  // even row first column west missing
    {2'd1, 3'd5, 1'b0, 17'h08020, 3'd7},  // odd row last column east missing
    {2'd0, 3'd5, 1'b0, 17'h0A000, 3'd4},  // even row last column west present
    {2'd3, 3'd0, 1'b0, 17'h09004, 3'd3},  // odd row first column east present
    {2'd2, 3'd3, 1'b1, 17'h12008, 3'd0},  // write own
    {2'd0, 3'd0, 1'b1, 17'h00040, 3'd7},  // write south missing
    {2'd3, 3'd1, 1'b1, 17'h18040, 3'd7}   // write north missing
  };

  task automatic drive(input logic [1:0] r, input logic [2:0] c, input logic we,
                       input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    tile_row = r; tile_col = c; req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
  endtask

  initial begin
    logic [31:0] exp_rd, exp2;
    repeat (3) @(negedge clk);
    // R10: request presented during reset gives no result
    tile_row = 2'd1; tile_col = 3'd2; req_valid = 1'b1; req_addr = 17'h10000;
    @(negedge clk);
    chk(32'(rd_valid), 0, "R10 rd_valid in reset");
    chk(32'(acc_err), 0, "R10 acc_err in reset");
    req_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
    chk(32'(port_req), 0, "R10 port_req idle");
    chk(32'(rd_valid), 0, "R10 rd_valid after reset");

    // table walk: R1 R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      int ep;
      logic [4:0] ereq;
      v = VEC[i];
      ep = int'(v[2:0]);
      ereq = (ep == NONE) ? 5'd0 : (5'd1 << ep);
      drive(v[25:24], v[23:21], v[20], v[19:3], 32'hC0DE_0000 ^ 32'(i));
      chk(32'(port_req), 32'(ereq), "R1 R2 port_req");
      chk(32'(port_we), v[20] ? 32'(ereq) : 0, "R5 port_we");
      chk(32'(port_bank), 32'(v[17:15]), "R3 port_bank");
      chk(32'(port_word), 32'(v[14:5]), "R3 port_word");
      chk(port_wdata, 32'hC0DE_0000 ^ 32'(i), "R3 port_wdata");
      exp_rd = (ep == NONE || v[20]) ? 32'd0 : mem[ep][v[17:5]];
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(32'(rd_valid), v[20] ? 0 : 1, "R7 R9 rd_valid");
      chk(rd_data, exp_rd, "R7 R8 rd_data");
      chk(32'(acc_err), (ep == NONE) ? 1 : 0, "R6 acc_err");
    end

    // R6: error lasts one cycle only
    @(negedge clk); #1;
    chk(32'(acc_err), 0, "R6 acc_err single cycle");

    // R4: no port while req_valid low
    tile_row = 2'd1; tile_col = 3'd2; req_addr = 17'h18000; req_valid = 1'b0; #1;
    chk(32'(port_req), 0, "R4 idle no port");

    // R5: write then read back
    drive(2'd1, 3'd2, 1'b1, 17'h10100, 32'h5A5A_1234);
    drive(2'd1, 3'd2, 1'b0, 17'h10100, 32'h0);
    @(negedge clk); req_valid = 1'b0; #1;
    chk(rd_data, 32'h5A5A_1234, "R5 readback");

    // R11: back-to-back reads to own then north
    exp_rd = mem[0][13'h010];
    exp2   = mem[1][13'h020];
    drive(2'd1, 3'd2, 1'b0, 17'h10040, 32'h0);
    drive(2'd1, 3'd2, 1'b0, 17'h18080, 32'h0);
    chk(rd_data, exp_rd, "R11 first read");
    @(negedge clk); req_valid = 1'b0; #1;
    chk(rd_data, exp2, "R11 second read");

    // R10: reset asserted with a pending read kills the result
    drive(2'd1, 3'd2, 1'b0, 17'h10000, 32'h0);
    rst = 1'b1;
    @(negedge clk); req_valid = 1'b0; #1;
    chk(32'(rd_valid), 0, "R10 reset drops read");
    rst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule